// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps a DRAM's contents alive. After reset it waits out a power-up pause and then runs a burst of initialization refresh cycles. Only after these does it declare the memory ready. From then on a free-running interval timer marks one refresh as owed per distributed interval. The normal setting gives 512 refreshes per 8 ms. A low-power setting stretches that period to 128 ms.

Refreshes are obtained from the access controller through a request/grant handshake. While the grant is held, the scheduler drives the row and column strobes itself for a column-before-row refresh cycle. Write enable stays high throughout, and no address is needed. A count of owed refreshes grows when grants are late, up to a saturation limit. Owed refreshes are then issued back-to-back once the grant arrives. A sticky flag records that the limit was hit and a refresh was lost.

Top module: `dram_refresh_sched`

## Requirements
- R1: For PAUSE_US*CLK_MHZ clock cycles after reset (10000 by default), `req` stays low, `ready` stays low and all strobes stay high, whatever `gnt` does.
- R2: After the pause, exactly INIT_CYCLES (default 8) refresh cycles are issued. `ready` rises after the precharge of the last one and then stays high until reset.
- R3: In every refresh cycle both column strobes (`cas_n` = 2'b00) go low at least CSR_CYC cycles before `ras_n` falls and are still low when it falls. They stay low for CHR_CYC cycles after the fall.
- R4: `ras_n` stays low for exactly RAS_CYC cycles (default 3) per refresh. It is high for at least RP_CYC cycles (default 2) before every fall.
- R5: `we_n` is high in every cycle in which `busy` is high.
- R6: Once `ready` is high, one refresh becomes owed every INTERVAL_CYC cycles, whatever the grant latency. That is 781 cycles for LOW_POWER=0 and 12500 cycles for LOW_POWER=1 at 50 MHz. With `gnt` held high, successive refreshes are therefore exactly that many cycles apart.
- R7: `req` is high exactly when `owed` is non-zero outside the pause. A refresh starts only in a cycle that follows a sampled high `gnt`. `owed` reports the refreshes not yet started.
- R8: With `gnt` high and several refreshes owed, they are issued back-to-back, with `ras_n` falls CSR_CYC+RAS_CYC+RP_CYC cycles (default 6) apart, until `owed` is zero.
- R9: `owed` never exceeds OWED_MAX (default 4) after `ready`. A tick that arrives at the limit sets `overflow`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gnt | input | 1 | Grant from the access controller; the strobes belong to this block while it is held |
| req | output | 1 | Refresh wanted |
| ready | output | 1 | Initialization done, memory usable |
| owed | output | OWW | Refreshes owed and not yet started |
| overflow | output | 1 | Sticky: the owed count saturated and a refresh was lost |
| busy | output | 1 | A refresh cycle is in progress on the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Upper and lower column strobes, active low |
| we_n | output | 1 | Write enable, held high |

## Verification
The hardest state to reach is a saturated backlog with the overflow flag set. It needs several interval ticks with no grant, and only after the long pause and the init burst have finished. The bench holds `gnt` low for six intervals, which pushes the count past its limit. It then restores `gnt` and checks that the saturated backlog drains back-to-back while `overflow` stays set. A second instance with the low-power setting runs alongside to measure the long interval.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,   // column strobes low, row strobe high
        SQ_HOLD,    // all strobes low
        SQ_RAS,     // row strobe low only
        SQ_PRE      // all high, row precharge
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_PAUSE,
        PH_INIT,
        PH_RUN
    } phase_e;

endpackage

// File: rtl/refsch_interval_timer.sv
module refsch_interval_timer #(
    parameter int PERIOD = 781
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(PERIOD + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(PERIOD - 1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: ticks are isolated single-cycle pulses
    a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/refsch_strobe_seq.sv
module refsch_strobe_seq
    import refsch_pkg::*;
#(
    parameter int CSR_CYC = 1,
    parameter int CHR_CYC = 1,
    parameter int RAS_CYC = 3,
    parameter int RP_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done,
    output logic busy,
    output logic ras_n,
    output logic cas_n
);
    localparam int M1   = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
    localparam int MAXC = (M1 > RP_CYC) ? M1 : RP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                if (start) begin
                    s_d.st  = SQ_SETUP;
                    s_d.cnt = '0;
                end
            end
            SQ_SETUP: begin
                if (s_q.cnt == CW'(CSR_CYC - 1)) begin
                    s_d.st  = SQ_HOLD;
                    s_d.cnt = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            SQ_HOLD: begin
                if (s_q.cnt == CW'(CHR_CYC - 1)) begin
                    s_d.st  = SQ_RAS;
                    s_d.cnt = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            SQ_RAS: begin
                if (s_q.cnt == CW'(RAS_CYC - CHR_CYC - 1)) begin
                    s_d.st  = SQ_PRE;
                    s_d.cnt = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            SQ_PRE: begin
                if (s_q.cnt == CW'(RP_CYC - 1)) begin
                    done    = 1'b1;
                    s_d.st  = start ? SQ_SETUP : SQ_IDLE;
                    s_d.cnt = '0;
                end else s_d.cnt = s_q.cnt + 1'b1;
            end
            default: s_d = '{st: SQ_IDLE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE, cnt: '0};
        else        s_q <= s_d;
    end

    assign busy  = (s_q.st != SQ_IDLE);
    assign ras_n = !((s_q.st == SQ_HOLD) || (s_q.st == SQ_RAS));
    assign cas_n = !((s_q.st == SQ_SETUP) || (s_q.st == SQ_HOLD));

    // Checker state: cycles the row strobe has been high, saturating
    localparam int HW = $clog2(RP_CYC + 2);
    logic [HW-1:0] hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    hi_q <= HW'(RP_CYC);
        else if (!ras_n)               hi_q <= '0;
        else if (hi_q < HW'(RP_CYC))   hi_q <= hi_q + 1'b1;
    end

    // R3: column strobes are already low in the cycle before the row strobe falls
    a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == 1'b0 && cas_n == 1'b0));

    // R4: enough precharge before each row strobe fall
    a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (hi_q >= HW'(RP_CYC)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import refsch_pkg::*;
#(
    parameter int CLK_MHZ      = 50,
    parameter int LOW_POWER    = 0,
    parameter int ROWS         = 512,
    parameter int PAUSE_US     = 200,
    parameter int INIT_CYCLES  = 8,
    parameter int OWED_MAX     = 4,
    parameter int CSR_CYC      = 1,
    parameter int CHR_CYC      = 1,
    parameter int RAS_CYC      = 3,
    parameter int RP_CYC       = 2,
    localparam int OWW = $clog2(((INIT_CYCLES > OWED_MAX) ? INIT_CYCLES : OWED_MAX) + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gnt,
    output logic           req,
    output logic           ready,
    output logic [OWW-1:0] owed,
    output logic           overflow,
    output logic           busy,
    output logic           ras_n,
    output logic [1:0]     cas_n,
    output logic           we_n
);
    localparam int PERIOD_MS    = (LOW_POWER != 0) ? 128 : 8;
    localparam int INTERVAL_NS  = PERIOD_MS * 1000000 / ROWS;
    localparam int INTERVAL_CYC = INTERVAL_NS * CLK_MHZ / 1000;
    localparam int PAUSE_CYC    = PAUSE_US * CLK_MHZ;
    localparam int PW           = $clog2(PAUSE_CYC + 1);

    typedef struct packed {
        phase_e         ph;
        logic [PW-1:0]  pcnt;
        logic [OWW-1:0] owed;
        logic           ovf;
    } top_t;

    top_t r_d, r_q;
    logic tick, start, seq_done, seq_busy, seq_ras_n, seq_cas_n;

    refsch_interval_timer #(.PERIOD(INTERVAL_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.ph == PH_RUN),
        .tick  (tick)
    );

    refsch_strobe_seq #(
        .CSR_CYC (CSR_CYC),
        .CHR_CYC (CHR_CYC),
        .RAS_CYC (RAS_CYC),
        .RP_CYC  (RP_CYC)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .done  (seq_done),
        .busy  (seq_busy),
        .ras_n (seq_ras_n),
        .cas_n (seq_cas_n)
    );

    always_comb begin
        r_d   = r_q;
        start = (r_q.ph != PH_PAUSE) && (r_q.owed != '0) && gnt
                && (!seq_busy || seq_done);
        case (r_q.ph)
            PH_PAUSE: begin
                if (r_q.pcnt == PW'(PAUSE_CYC - 1)) begin
                    r_d.ph   = PH_INIT;
                    r_d.owed = OWW'(INIT_CYCLES);
                end else r_d.pcnt = r_q.pcnt + 1'b1;
            end
            PH_INIT: begin
                if (start) r_d.owed = r_q.owed - 1'b1;
                else if (seq_done && r_q.owed == '0) r_d.ph = PH_RUN;
            end
            PH_RUN: begin
                if (tick && !start) begin
                    if (r_q.owed == OWW'(OWED_MAX)) r_d.ovf  = 1'b1;
                    else                           r_d.owed = r_q.owed + 1'b1;
                end else if (start && !tick) begin
                    r_d.owed = r_q.owed - 1'b1;
                end
            end
            default: r_d.ph = PH_PAUSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ph: PH_PAUSE, pcnt: '0, owed: '0, ovf: 1'b0};
        else        r_q <= r_d;
    end

    assign req      = (r_q.ph != PH_PAUSE) && (r_q.owed != '0);
    assign ready    = (r_q.ph == PH_RUN);
    assign owed     = r_q.owed;
    assign overflow = r_q.ovf;
    assign busy     = seq_busy;
    assign ras_n    = seq_ras_n;
    assign cas_n    = {2{seq_cas_n}};
    assign we_n     = 1'b1;

    // R1: strobes idle during the power-up pause
    a_r1_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ph == PH_PAUSE) |-> (ras_n && cas_n == 2'b11 && !busy));

    // R2: ready never drops once raised
    a_r2_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R7: a refresh cycle begins only after a sampled grant
    a_r7_start_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n[0]) |-> $past(gnt));

    // R9: owed count bounded during normal operation
    a_r9_owed_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (owed <= OWW'(OWED_MAX)));

    // R9: overflow is sticky
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
    localparam int PAUSE_CYC = 10000;
    localparam int INTV      = 781;
    localparam int INTV_LP   = 12500;
    localparam int B2B       = 6;
    localparam int OMAX      = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b1;
    logic req, ready, overflow, busy, ras_n, we_n;
    logic [3:0] owed;
    logic [1:0] cas_n;

    logic req_l, ready_l, overflow_l, busy_l, ras_n_l, we_n_l;
    logic [3:0] owed_l;
    logic [1:0] cas_n_l;

    int checks = 0, fails = 0;
    int cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_sched uut (
        .clk(clk), .rst_n(rst_n), .gnt(gnt), .req(req), .ready(ready),
        .owed(owed), .overflow(overflow), .busy(busy), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n));

    dram_refresh_sched #(.LOW_POWER(1)) uut_lp (
        .clk(clk), .rst_n(rst_n), .gnt(1'b1), .req(req_l), .ready(ready_l),
        .owed(owed_l), .overflow(overflow_l), .busy(busy_l), .ras_n(ras_n_l),
        .cas_n(cas_n_l), .we_n(we_n_l));

    // Strobe monitor for the main instance
    int nfall = 0, last_fall = 0, prev_fall = 0;
    int lo_run = 0, hi_run = 100;
    int v_r3 = 0, v_r4 = 0, v_r5 = 0;
    logic p_ras = 1'b1;
    logic [1:0] p_cas = 2'b11;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                nfall++; prev_fall = last_fall; last_fall = cyc;
                if (!(p_cas == 2'b00 && cas_n == 2'b00)) v_r3++;
                if (hi_run < 2) v_r4++;
                lo_run = 1;
            end else if (!ras_n) lo_run++;
            if (!p_ras && ras_n) begin
                if (lo_run != 3) v_r4++;
                hi_run = 1;
            end else if (ras_n) hi_run++;
            if (busy && !we_n) v_r5++;
        end
        p_ras = ras_n;
        p_cas = cas_n;
    end

    int nfall_l = 0, last_l = 0, prev_l = 0;
    logic p_ras_l = 1'b1;
    always @(negedge clk) begin
        if (rst_n && p_ras_l && !ras_n_l) begin
            nfall_l++; prev_l = last_l; last_l = cyc;
        end
        p_ras_l = ras_n_l;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic wait_falls(input int target);
        while (nfall < target) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(req == 0 && ready == 0 && ras_n && cas_n == 2'b11 && !overflow && owed == 0,
            "R1", "reset state req/ready/ras", {req, ready, ras_n}, 1);
        rst_n = 1'b1;
    endtask

    task automatic t_pause;   // R1
        int t0 = cyc;
        bit quiet = 1;
        while (cyc - t0 < PAUSE_CYC - 10) begin
            @(negedge clk);
            if (req || ready || !ras_n || cas_n != 2'b11) quiet = 0;
        end
        chk(quiet, "R1", "quiet during pause", quiet, 1);
        repeat (20) @(negedge clk);
        chk(busy || req, "R1", "refresh requested after pause", {busy, req}, 1);
    endtask

    task automatic t_init;    // R2
        int guard = 0;
        while (!ready && guard < 200) begin @(negedge clk); guard++; end
        chk(nfall == 8, "R2", "init refresh count", nfall, 8);
        chk(ready == 1, "R2", "ready after init", ready, 1);
        chk(owed == 0 && !req, "R7", "nothing owed after init", owed, 0);
    endtask

    task automatic t_interval; // R6
        wait_falls(9);
        wait_falls(10);
        chk(last_fall - prev_fall == INTV, "R6", "normal interval",
            last_fall - prev_fall, INTV);
    endtask

    task automatic t_backlog;  // R7, R8
        int base;
        @(negedge clk); gnt = 1'b0;
        base = nfall;
        repeat (3 * INTV + 50) @(negedge clk);
        chk(owed == 3, "R7", "owed after three missed ticks", owed, 3);
        chk(req == 1 && nfall == base, "R7", "no refresh without grant", nfall - base, 0);
        gnt = 1'b1;
        wait_falls(base + 2);
        chk(last_fall - prev_fall == B2B, "R8", "back-to-back spacing 1", last_fall - prev_fall, B2B);
        wait_falls(base + 3);
        chk(last_fall - prev_fall == B2B, "R8", "back-to-back spacing 2", last_fall - prev_fall, B2B);
        @(negedge clk);
        chk(owed == 0 && !req, "R8", "backlog drained", owed, 0);
    endtask

    task automatic t_overflow; // R9
        int base;
        chk(overflow == 0, "R9", "no overflow before saturation", overflow, 0);
        gnt = 1'b0;
        base = nfall;
        repeat (6 * INTV + 50) @(negedge clk);
        chk(owed == OMAX, "R9", "owed saturates", owed, OMAX);
        chk(overflow == 1, "R9", "overflow set", overflow, 1);
        gnt = 1'b1;
        wait_falls(base + 4);
        chk(last_fall - prev_fall == B2B, "R8", "saturated drain spacing", last_fall - prev_fall, B2B);
        repeat (8) @(negedge clk);
        chk(nfall == base + 4, "R9", "exactly limit refreshes drained", nfall - base, OMAX);
        chk(overflow == 1, "R9", "overflow sticky", overflow, 1);
        chk(owed == 0, "R9", "owed zero after drain", owed, 0);
    endtask

    task automatic t_protocol; // R3, R4, R5
        chk(v_r3 == 0, "R3", "column-before-row violations", v_r3, 0);
        chk(v_r4 == 0, "R4", "row low width / precharge violations", v_r4, 0);
        chk(v_r5 == 0, "R5", "write enable low while busy", v_r5, 0);
        chk(we_n == 1, "R5", "write enable level", we_n, 1);
    endtask

    task automatic t_lowpower; // R6
        while (nfall_l < 10) @(negedge clk);
        chk(last_l - prev_l == INTV_LP, "R6", "low-power interval", last_l - prev_l, INTV_LP);
        chk(ready_l == 1 && overflow_l == 0, "R6", "low-power ready, no overflow",
            {ready_l, overflow_l}, 2);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        t_pause;
        t_init;
        t_interval;
        t_backlog;
        t_overflow;
        t_protocol;
        t_lowpower;
        summary;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary;
    end
endmodule